// File: doc/BRIEF.md
# Control Register Access Unit

This block owns a handful of control and status registers and executes the three read-modify-write register instructions. Each instruction can replace the whole value, set selected bits or clear selected bits. Each one takes either a full register operand or a 5-bit immediate. A request gives a 12-bit register address, a 3-bit operation code and an operand, qualified by a valid strobe. One clock later the unit returns the masked old value, which the pipeline writes back to the destination register. The same response says whether that write-back may happen or whether an illegal-instruction fault was raised.

The implemented registers are:

| Address | Register |
|---|---|
| 0x001 | Accrued floating-point flags, 5 bits |
| 0x002 | Rounding mode, 3 bits |
| 0x003 | Combined floating-point control view of the two fields above, no storage of its own |
| 0x340 | Full-width scratch register |
| 0x7C0 | Register that keeps only the bits set in a parameter mask |
| 0xC12 | Read-only identification constant |

Every value is ANDed with its register's mask on the way out and on the way in. The unit stores a new value only when the masked result differs from the masked old value. Read-only registers are identified by their address alone. An access to a read-only register faults only when it would change the value.

Top module: `csr_rmw_unit`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and every writable register (flags, rounding mode, scratch, masked register) reads 0.
- R2: A request accepted at a clock edge with `req_valid`=1 produces `rsp_valid`=1 after that edge. `rsp_valid` is 0 after any edge at which `req_valid` was 0.
- R3: `req_op[1:0]` selects the action: 01 replaces the value with the source, 10 sets it to old OR source, and 11 sets it to old AND NOT source. `req_op[2]`=1 makes the source `req_operand[4:0]` zero-extended; otherwise the source is the full operand. `req_op[1:0]`=00 is reserved: it faults and changes nothing.
- R4: `rsp_rdata` is the register's value before the request, ANDed with its mask. `rsp_wb_en` is 1 when the request did not fault.
- R5: Address 0x003 reads as the flags in bits 4:0 and the rounding mode in bits 7:5, with zeros above. Address 0x001 exposes only the flags, and 0x002 only the rounding mode.
- R6: A write through 0x003 loads the flags from bits 4:0 and the rounding mode from bits 7:5 of the masked new value. Writing 0x001 or 0x002 leaves the other field untouched.
- R7: Masks are 0x1F for the flags, 0x07 for the rounding mode, 0xFF for the combined view, all ones for the scratch and the identification register, and `MASKED_MASK` (default 0x0000F0F0) for 0x7C0. Bits outside a mask are never stored and always read as 0.
- R8: An access to an address other than the six implemented ones raises `rsp_illegal`, returns 0 and changes no register.
- R9: A register whose address has bits 11:10 equal to 11 is read-only. An access whose masked new value differs from the masked old value raises `rsp_illegal` and changes nothing.
- R10: An access to a read-only register that leaves its masked value unchanged completes without a fault and returns its value (default 0xA5C30F01).
- R11: Whenever `rsp_illegal` is 1, `rsp_wb_en` is 0.
- R12: No register changes except as the result of an accepted, non-faulting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 12 | Register address |
| req_op | input | 3 | Operation code: bit 2 selects immediate, bits 1:0 select the action |
| req_operand | input | XLEN | Register operand; bits 4:0 are the immediate |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | XLEN | Masked old value, 0 for an unimplemented address |
| rsp_wb_en | output | 1 | Destination write-back permitted |
| rsp_illegal | output | 1 | Illegal-instruction fault |

## Verification
The hardest case to reach from the ports is an access to a read-only register that does not fault. It requires a set whose source bits are already 1 in the constant, or a clear whose source bits are already 0, and the register form must carry an exactly matching value. The bench reaches it with a full product of addresses, all eight operation codes and operands chosen to overlap the identification constant both fully and partially. A reference model computed in the bench decides which of these combinations must fault. A further sweep of all 4096 addresses with a set of immediate zero covers two things: it confirms the decoding of unimplemented addresses, and it shows that the non-changing read-only access passes.

// File: rtl/csr_rmw_pkg.sv
// Shared definitions for the control register access unit: register
// selectors, action encoding and the fixed addresses of the register set.
// Assumes the 12-bit address space and the 5-bit immediate of the
// read-modify-write register instructions.
package csr_rmw_pkg;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned IMM_W   = 5;
    localparam int unsigned FLAGS_W = 5;
    localparam int unsigned RMODE_W = 3;
    localparam int unsigned FPCTL_W = FLAGS_W + RMODE_W;

    localparam logic [ADDR_W-1:0] A_FLAGS   = 12'h001;
    localparam logic [ADDR_W-1:0] A_RMODE   = 12'h002;
    localparam logic [ADDR_W-1:0] A_FPCTL   = 12'h003;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
    localparam logic [ADDR_W-1:0] A_MASKED  = 12'h7C0;
    localparam logic [ADDR_W-1:0] A_IDENT   = 12'hC12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FLAGS,
        SEL_RMODE,
        SEL_FPCTL,
        SEL_SCRATCH,
        SEL_MASKED,
        SEL_IDENT
    } csr_sel_e;

    typedef enum logic [1:0] {
        ACT_RSVD  = 2'b00,
        ACT_WRITE = 2'b01,
        ACT_SET   = 2'b10,
        ACT_CLEAR = 2'b11
    } csr_act_e;

endpackage

// File: rtl/csr_addr_decode.sv
// Address decoder: maps a 12-bit register address onto a selector, the
// register's mask and its read-only attribute.
// Assumes the read-only attribute depends on address bits 11:10 only, and
// that an unimplemented address gets a zero mask so that it reads as zero.
module csr_addr_decode
    import csr_rmw_pkg::*;
#(
    parameter int unsigned    XLEN        = 32,
    parameter logic [XLEN-1:0] MASKED_MASK = 32'h0000_F0F0
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_e          sel,
    output logic [XLEN-1:0]   mask,
    output logic              implemented,
    output logic              read_only
);

    localparam logic [XLEN-1:0] FLAGS_MASK = XLEN'((1 << FLAGS_W) - 1);
    localparam logic [XLEN-1:0] RMODE_MASK = XLEN'((1 << RMODE_W) - 1);
    localparam logic [XLEN-1:0] FPCTL_MASK = XLEN'((1 << FPCTL_W) - 1);

    // Attribute from the address class bits
    assign read_only = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);

    // Selector and mask lookup
    always_comb begin
        sel  = SEL_NONE;
        mask = '0;
        case (addr)
            A_FLAGS:   begin sel = SEL_FLAGS;   mask = FLAGS_MASK;  end
            A_RMODE:   begin sel = SEL_RMODE;   mask = RMODE_MASK;  end
            A_FPCTL:   begin sel = SEL_FPCTL;   mask = FPCTL_MASK;  end
            A_SCRATCH: begin sel = SEL_SCRATCH; mask = '1;          end
            A_MASKED:  begin sel = SEL_MASKED;  mask = MASKED_MASK; end
            A_IDENT:   begin sel = SEL_IDENT;   mask = '1;          end
            default:   begin sel = SEL_NONE;    mask = '0;          end
        endcase
    end

    assign implemented = (sel != SEL_NONE);

endmodule

// File: rtl/csr_new_value.sv
// New-value generator: picks register or zero-extended immediate source,
// applies replace, set or clear to the masked old value and masks the
// result. Assumes the old value is already masked.
module csr_new_value
    import csr_rmw_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] operand,
    input  logic [XLEN-1:0] old_m,
    input  logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] new_m,
    output logic            op_legal
);

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] raw;
    csr_act_e        act;

    assign act = csr_act_e'(op[1:0]);

    // Operand source: immediate field or full register value
    assign src = op[2] ? {{(XLEN-IMM_W){1'b0}}, operand[IMM_W-1:0]} : operand;

    // Action on the old value
    always_comb begin
        op_legal = 1'b1;
        case (act)
            ACT_WRITE: raw = src;
            ACT_SET:   raw = old_m | src;
            ACT_CLEAR: raw = old_m & ~src;
            default: begin
                raw      = old_m;
                op_legal = 1'b0;
            end
        endcase
    end

    assign new_m = raw & mask;

endmodule

// File: rtl/csr_rmw_unit.sv
// Control register access unit (top). Holds the flag, rounding-mode,
// scratch and masked registers, serves the combined floating-point view
// and the read-only identification constant, and returns a registered
// response one cycle after each request.
// Assumes one request per cycle at most, no privilege checks, and that the
// consumer writes the destination only when rsp_wb_en is set.
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int unsigned     XLEN        = 32,
    parameter logic [XLEN-1:0] MASKED_MASK = 32'h0000_F0F0,
    parameter logic [XLEN-1:0] IDENT_VALUE = 32'hA5C3_0F01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_op,
    input  logic [XLEN-1:0]      req_operand,
    output logic                 rsp_valid,
    output logic [XLEN-1:0]      rsp_rdata,
    output logic                 rsp_wb_en,
    output logic                 rsp_illegal
);

    csr_sel_e         sel;
    logic [XLEN-1:0]  mask;
    logic             implemented;
    logic             read_only;
    logic [XLEN-1:0]  old_raw;
    logic [XLEN-1:0]  old_m;
    logic [XLEN-1:0]  new_m;
    logic             op_legal;
    logic             changes;
    logic             fault;
    logic             do_write;

    logic [FLAGS_W-1:0] flags_q;
    logic [RMODE_W-1:0] rmode_q;
    logic [XLEN-1:0]    scratch_q;
    logic [XLEN-1:0]    masked_q;

    csr_addr_decode #(
        .XLEN        (XLEN),
        .MASKED_MASK (MASKED_MASK)
    ) u_decode (
        .addr        (req_addr),
        .sel         (sel),
        .mask        (mask),
        .implemented (implemented),
        .read_only   (read_only)
    );

    // Read path: gather the current value of the selected register
    always_comb begin
        case (sel)
            SEL_FLAGS:   old_raw = {{(XLEN-FLAGS_W){1'b0}}, flags_q};
            SEL_RMODE:   old_raw = {{(XLEN-RMODE_W){1'b0}}, rmode_q};
            SEL_FPCTL:   old_raw = {{(XLEN-FPCTL_W){1'b0}}, rmode_q, flags_q};
            SEL_SCRATCH: old_raw = scratch_q;
            SEL_MASKED:  old_raw = masked_q;
            SEL_IDENT:   old_raw = IDENT_VALUE;
            default:     old_raw = '0;
        endcase
    end

    assign old_m = old_raw & mask;

    csr_new_value #(
        .XLEN (XLEN)
    ) u_newval (
        .op       (req_op),
        .operand  (req_operand),
        .old_m    (old_m),
        .mask     (mask),
        .new_m    (new_m),
        .op_legal (op_legal)
    );

    // Fault and write decision
    assign changes  = (new_m != old_m);
    assign fault    = !implemented || !op_legal || (read_only && changes);
    assign do_write = req_valid && !fault && changes;

    // Register storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            rmode_q   <= '0;
            scratch_q <= '0;
            masked_q  <= '0;
        end else if (do_write) begin
            case (sel)
                SEL_FLAGS:   flags_q   <= new_m[FLAGS_W-1:0];
                SEL_RMODE:   rmode_q   <= new_m[RMODE_W-1:0];
                SEL_FPCTL: begin
                    flags_q <= new_m[FLAGS_W-1:0];
                    rmode_q <= new_m[FPCTL_W-1:FLAGS_W];
                end
                SEL_SCRATCH: scratch_q <= new_m;
                SEL_MASKED:  masked_q  <= new_m;
                default: ;
            endcase
        end
    end

    // Response registers, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_wb_en   <= 1'b0;
            rsp_illegal <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_rdata   <= req_valid ? old_m : '0;
            rsp_wb_en   <= req_valid && !fault;
            rsp_illegal <= req_valid && fault;
        end
    end

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_fault_blocks_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> !rsp_wb_en);

    p_fault_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> ($stable(flags_q) && $stable(rmode_q)
                         && $stable(scratch_q) && $stable(masked_q)));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(flags_q) && $stable(rmode_q)
                        && $stable(scratch_q) && $stable(masked_q)));

    p_mask_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_q & ~MASKED_MASK) == '0);

endmodule

// File: tb/csr_rmw_unit_test.sv
module csr_rmw_unit_test;

    localparam int unsigned XLEN = 32;
    localparam logic [31:0] M_MASK = 32'h0000_F0F0;
    localparam logic [31:0] IDENT  = 32'hA5C3_0F01;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [11:0] req_addr;
    logic [2:0]  req_op;
    logic [31:0] req_operand;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_wb_en;
    logic        rsp_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state
    logic [4:0]  m_flags;
    logic [2:0]  m_rmode;
    logic [31:0] m_scratch;
    logic [31:0] m_masked;

    always #2 clk = ~clk;

    csr_rmw_unit #(
        .XLEN        (XLEN),
        .MASKED_MASK (M_MASK),
        .IDENT_VALUE (IDENT)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_op      (req_op),
        .req_operand (req_operand),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_wb_en   (rsp_wb_en),
        .rsp_illegal (rsp_illegal)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Issue one request, predict the result from the requirements, check it
    task automatic access(input logic [11:0] a, input logic [2:0] op,
                          input logic [31:0] opd);
        logic        impl, ro, ill, chg;
        logic [31:0] msk, cur, old, src, nv;
        string       tag;
        impl = 1'b1;
        ro   = (a[11:10] == 2'b11);
        case (a)
            12'h001: begin msk = 32'h1F; cur = {27'b0, m_flags}; end
            12'h002: begin msk = 32'h07; cur = {29'b0, m_rmode}; end
            12'h003: begin msk = 32'hFF; cur = {24'b0, m_rmode, m_flags}; end
            12'h340: begin msk = '1;     cur = m_scratch; end
            12'h7C0: begin msk = M_MASK; cur = m_masked; end
            12'hC12: begin msk = '1;     cur = IDENT; end
            default: begin impl = 1'b0; msk = '0; cur = '0; end
        endcase
        old = cur & msk;
        src = op[2] ? {27'b0, opd[4:0]} : opd;
        case (op[1:0])
            2'b01:   nv = src;
            2'b10:   nv = old | src;
            2'b11:   nv = old & ~src;
            default: nv = old;
        endcase
        nv  = nv & msk;
        chg = (nv != old);
        ill = !impl || (op[1:0] == 2'b00) || (ro && chg);

        if (!impl)                 tag = "R8";
        else if (op[1:0] == 2'b00) tag = "R3";
        else if (ro && ill)        tag = "R9";
        else if (ro)               tag = "R10";
        else if (a == 12'h003)     tag = "R5";
        else if (a == 12'h7C0)     tag = "R7";
        else                       tag = "R4";

        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_op      = op;
        req_operand = opd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk(tag, "rdata", rsp_rdata, old);
        chk(tag, "illegal", {31'b0, rsp_illegal}, {31'b0, ill});
        chk(ill ? "R11" : "R4", "wb_en", {31'b0, rsp_wb_en}, {31'b0, !ill});

        if (!ill && chg) begin
            case (a)
                12'h001: m_flags   = nv[4:0];
                12'h002: m_rmode   = nv[2:0];
                12'h003: begin m_flags = nv[4:0]; m_rmode = nv[7:5]; end
                12'h340: m_scratch = nv;
                12'h7C0: m_masked  = nv;
                default: ;
            endcase
        end
    endtask

    initial begin
        logic [11:0] addrs [8];
        logic [31:0] opds  [7];
        addrs = '{12'h001, 12'h002, 12'h003, 12'h340, 12'h7C0, 12'hC12, 12'hC13, 12'h000};
        opds  = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0000_001F,
                  32'h1234_5678, 32'hA5C3_0F01, 32'h0000_0005};
        m_flags = '0; m_rmode = '0; m_scratch = '0; m_masked = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_op = '0; req_operand = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

        // R1: writable registers read zero after reset (set with imm 0)
        access(12'h001, 3'b110, 32'h0);
        access(12'h002, 3'b110, 32'h0);
        access(12'h340, 3'b110, 32'h0);
        access(12'h7C0, 3'b110, 32'h0);
        @(negedge clk);
        chk("R2", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);

        // R5, R6: composite write splits, separate views stay independent
        access(12'h003, 3'b001, 32'hFFFF_FFE5);
        access(12'h001, 3'b110, 32'h0);
        chk("R6", "flags via composite", rsp_rdata, 32'h05);
        access(12'h002, 3'b110, 32'h0);
        chk("R6", "rmode via composite", rsp_rdata, 32'h07);
        access(12'h001, 3'b001, 32'hFF);
        access(12'h003, 3'b110, 32'h0);
        chk("R6", "composite after flags write", rsp_rdata, 32'hFF);

        // R10: read-only set of bits already set passes
        access(12'hC12, 3'b010, 32'h0000_0F01);
        chk("R10", "ident no-change set", {31'b0, rsp_illegal}, 32'd0);
        // R9: read-only change faults
        access(12'hC12, 3'b101, 32'h0000_0002);
        chk("R9", "ident change faults", {31'b0, rsp_illegal}, 32'd1);

        // Near-exhaustive product sweep over addresses, ops, operands
        for (int i = 0; i < 8; i++)
            for (int o = 0; o < 8; o++)
                for (int k = 0; k < 7; k++)
                    access(addrs[i], 3'(o), opds[k]);

        // R8: full address sweep with a non-changing set
        for (int a = 0; a < 4096; a++)
            access(12'(a), 3'b110, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule